// File: doc/BRIEF.md
# Four-Lane Pipelined Radix-4 Butterfly

This block is the arithmetic core of a fixed-point FFT engine. Each clock it can take one group of four complex samples and three complex twiddle factors. Samples 1, 2 and 3 are multiplied by their own twiddle, and sample 0 passes through unchanged. The block then forms the four radix-4 outputs from the sample and the three products. The result for a group appears on the outputs exactly four clocks after the group is presented.

The butterfly never stalls. Because of this, a single instance can serve every pass of a transform while the surrounding sequencer feeds it one group per cycle. Product rounding, overflow saturation and the final divide-by-four are fixed inside the block, so every output stays in the same 16-bit format as the inputs. Twiddle storage, address generation and pass sequencing belong to the surrounding logic.

Top module: `r4bf_top`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `out_valid` is 0 and `out_re`/`out_im` are all zero.
- R2: `out_valid` equals `in_valid` from exactly four rising clock edges earlier, and the result data for that group is on `out_re`/`out_im` in the same cycle.
- R3: A new group is accepted on every rising edge with `in_valid` high, with no stall. Back-to-back groups give results on consecutive cycles, each matching its own group.
- R4: Lane k of a bus occupies bits [16k+15:16k]. Twiddle leg k (k = 1..3) occupies bits [16(k-1)+15:16(k-1)] of `tw_re`/`tw_im` and multiplies input lane k. Input lane 0 is not multiplied. With a = x0, b = x1·w1, c = x2·w2, d = x3·w3, the output lanes are 0: a+b+c+d, 1: a−jb−c+jd, 2: a−b+c−d, 3: a+jb−c−jd, each divided by four.
- R5: A twiddled sample is computed with 16-bit signed Q1.15 twiddles. The real part is (xr·wr − xi·wi + 2^14) >> 15 and the imaginary part is (xr·wi + xi·wr + 2^14) >> 15, using an arithmetic shift, so that halves round toward +infinity.
- R6: A twiddled part that falls outside the signed 16-bit range is saturated to 32767 or −32768.
- R7: The divide-by-four is an arithmetic right shift by two, which rounds toward −infinity. Example: with all twiddles zero and x0 = −1 + 3j, every output lane is −1 + 0j.
- R8: While `out_valid` is low, `out_re` and `out_im` keep the last valid result. Groups presented with `in_valid` low change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Group on the inputs is to be processed |
| in_re | input | 64 | Real parts of input lanes 0..3 |
| in_im | input | 64 | Imaginary parts of input lanes 0..3 |
| tw_re | input | 48 | Real parts of twiddles for legs 1..3, Q1.15 |
| tw_im | input | 48 | Imaginary parts of twiddles for legs 1..3, Q1.15 |
| out_valid | output | 1 | Result group present on the outputs |
| out_re | output | 64 | Real parts of output lanes 0..3 |
| out_im | output | 64 | Imaginary parts of output lanes 0..3 |

## Verification
The bench builds the block with its default 16-bit sample width and 16-bit Q1.15 twiddles, the width that all bit positions above are stated for. At this width the bench can drive the most negative operand, −32768, into both sample and twiddle. That reaches the saturation cases of the complex multiply in both signs. A twiddle of exactly one half (16384) places products on exact rounding ties, and single-unit samples expose the floor behaviour of the divide-by-four. A gapped valid pattern with changing data on idle cycles shows that results are held between valid groups.

// File: rtl/r4bf_pkg.sv
`timescale 1ns/1ps
package r4bf_pkg;
  localparam int NLANE  = 4;
  localparam int NLEG   = NLANE - 1;
  localparam int NSTAGE = 4;
  localparam int S_CAP  = 0;
  localparam int S_MUL  = 1;
  localparam int S_PAIR = 2;
  localparam int S_OUT  = 3;
endpackage

// File: rtl/r4bf_vpipe.sv
`timescale 1ns/1ps
module r4bf_vpipe #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_in,
  output logic [DEPTH-1:0] v_stage
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic v_prev;
    if (s == 0) begin : g_head
      assign v_prev = v_in;
    end else begin : g_tail
      assign v_prev = v_stage[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_stage[s] <= 1'b0;
      else        v_stage[s] <= v_prev;
    end
  end
endmodule

// File: rtl/r4bf_cmul.sv
`timescale 1ns/1ps
module r4bf_cmul #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [DW-1:0] x_re,
  input  logic signed [DW-1:0] x_im,
  input  logic signed [TW-1:0] w_re,
  input  logic signed [TW-1:0] w_im,
  output logic signed [DW-1:0] p_re,
  output logic signed [DW-1:0] p_im
);
  localparam int MW = DW + TW;
  localparam int PW = MW + 1;
  localparam int XW = PW - DW + 1;
  localparam logic signed [PW-1:0] RND = {{(PW-1){1'b0}}, 1'b1} << (TW - 2);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  // a*c +/- b*d at full precision
  function automatic logic signed [PW-1:0] dot2(
    input logic signed [DW-1:0] a,
    input logic signed [DW-1:0] b,
    input logic signed [TW-1:0] c,
    input logic signed [TW-1:0] d,
    input logic                 minus
  );
    logic signed [MW-1:0] ac;
    logic signed [MW-1:0] bd;
    ac = MW'(a) * MW'(c);
    bd = MW'(b) * MW'(d);
    return minus ? (PW'(ac) - PW'(bd)) : (PW'(ac) + PW'(bd));
  endfunction

  // round half up to the data grid, then clamp to the data width
  function automatic logic signed [DW-1:0] round_sat(input logic signed [PW-1:0] v);
    logic signed [PW-1:0] t;
    t = (v + RND) >>> (TW - 1);
    if (t[PW-1:DW-1] == {XW{t[PW-1]}}) return t[DW-1:0];
    return t[PW-1] ? MINV : MAXV;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_re <= '0;
      p_im <= '0;
    end else if (en) begin
      p_re <= round_sat(dot2(x_re, x_im, w_re, w_im, 1'b1));
      p_im <= round_sat(dot2(x_re, x_im, w_im, w_re, 1'b0));
    end
  end
endmodule

// File: rtl/r4bf_pair.sv
`timescale 1ns/1ps
module r4bf_pair #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  input  logic signed [W-1:0] c_re,
  input  logic signed [W-1:0] c_im,
  input  logic signed [W-1:0] d_re,
  input  logic signed [W-1:0] d_im,
  output logic signed [W:0]   sac_re,
  output logic signed [W:0]   sac_im,
  output logic signed [W:0]   dac_re,
  output logic signed [W:0]   dac_im,
  output logic signed [W:0]   sbd_re,
  output logic signed [W:0]   sbd_im,
  output logic signed [W:0]   dbd_re,
  output logic signed [W:0]   dbd_im
);
  function automatic logic signed [W:0] grow_add(
    input logic signed [W-1:0] x,
    input logic signed [W-1:0] y,
    input logic                minus
  );
    logic signed [W:0] xe;
    logic signed [W:0] ye;
    xe = {x[W-1], x};
    ye = {y[W-1], y};
    return minus ? (xe - ye) : (xe + ye);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sac_re <= '0; sac_im <= '0;
      dac_re <= '0; dac_im <= '0;
      sbd_re <= '0; sbd_im <= '0;
      dbd_re <= '0; dbd_im <= '0;
    end else if (en) begin
      sac_re <= grow_add(a_re, c_re, 1'b0);
      sac_im <= grow_add(a_im, c_im, 1'b0);
      dac_re <= grow_add(a_re, c_re, 1'b1);
      dac_im <= grow_add(a_im, c_im, 1'b1);
      sbd_re <= grow_add(b_re, d_re, 1'b0);
      sbd_im <= grow_add(b_im, d_im, 1'b0);
      dbd_re <= grow_add(b_re, d_re, 1'b1);
      dbd_im <= grow_add(b_im, d_im, 1'b1);
    end
  end
endmodule

// File: rtl/r4bf_merge.sv
`timescale 1ns/1ps
module r4bf_merge #(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic signed [W:0] sac_re,
  input  logic signed [W:0] sac_im,
  input  logic signed [W:0] dac_re,
  input  logic signed [W:0] dac_im,
  input  logic signed [W:0] sbd_re,
  input  logic signed [W:0] sbd_im,
  input  logic signed [W:0] dbd_re,
  input  logic signed [W:0] dbd_im,
  output logic [4*W-1:0]    y_re,
  output logic [4*W-1:0]    y_im
);
  // second-level add or subtract, then keep the top W bits (floor of /4)
  function automatic logic [W-1:0] quarter(
    input logic signed [W:0] x,
    input logic signed [W:0] y,
    input logic              minus
  );
    logic signed [W+1:0] s;
    s = minus ? ({x[W], x} - {y[W], y}) : ({x[W], x} + {y[W], y});
    return s[W+1:2];
  endfunction

  logic [4*W-1:0] nxt_re;
  logic [4*W-1:0] nxt_im;

  always_comb begin
    // lane 0: (a+c)+(b+d)
    nxt_re[0*W +: W] = quarter(sac_re, sbd_re, 1'b0);
    nxt_im[0*W +: W] = quarter(sac_im, sbd_im, 1'b0);
    // lane 1: (a-c) - j(b-d): swap parts, negate the new imaginary part
    nxt_re[1*W +: W] = quarter(dac_re, dbd_im, 1'b0);
    nxt_im[1*W +: W] = quarter(dac_im, dbd_re, 1'b1);
    // lane 2: (a+c)-(b+d)
    nxt_re[2*W +: W] = quarter(sac_re, sbd_re, 1'b1);
    nxt_im[2*W +: W] = quarter(sac_im, sbd_im, 1'b1);
    // lane 3: (a-c) + j(b-d): swap parts, negate the new real part
    nxt_re[3*W +: W] = quarter(dac_re, dbd_im, 1'b1);
    nxt_im[3*W +: W] = quarter(dac_im, dbd_re, 1'b0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_re <= '0;
      y_im <= '0;
    end else if (en) begin
      y_re <= nxt_re;
      y_im <= nxt_im;
    end
  end
endmodule

// File: rtl/r4bf_top.sv
`timescale 1ns/1ps
module r4bf_top #(
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [r4bf_pkg::NLANE*DW-1:0] in_re,
  input  logic [r4bf_pkg::NLANE*DW-1:0] in_im,
  input  logic [r4bf_pkg::NLEG*TW-1:0]  tw_re,
  input  logic [r4bf_pkg::NLEG*TW-1:0]  tw_im,
  output logic                          out_valid,
  output logic [r4bf_pkg::NLANE*DW-1:0] out_re,
  output logic [r4bf_pkg::NLANE*DW-1:0] out_im
);
  import r4bf_pkg::*;

  // per-stage valid, brought out by name for the checker
  logic [NSTAGE-1:0] v_stage;

  r4bf_vpipe #(.DEPTH(NSTAGE)) u_vpipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .v_in    (in_valid),
    .v_stage (v_stage)
  );

  // stage 1: capture samples and twiddles
  logic signed [DW-1:0] s1_re [NLANE];
  logic signed [DW-1:0] s1_im [NLANE];
  logic signed [TW-1:0] s1_wre [NLEG];
  logic signed [TW-1:0] s1_wim [NLEG];

  for (genvar i = 0; i < NLANE; i++) begin : g_cap_x
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_re[i] <= '0;
        s1_im[i] <= '0;
      end else if (in_valid) begin
        s1_re[i] <= in_re[i*DW +: DW];
        s1_im[i] <= in_im[i*DW +: DW];
      end
    end
  end

  for (genvar k = 0; k < NLEG; k++) begin : g_cap_w
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_wre[k] <= '0;
        s1_wim[k] <= '0;
      end else if (in_valid) begin
        s1_wre[k] <= tw_re[k*TW +: TW];
        s1_wim[k] <= tw_im[k*TW +: TW];
      end
    end
  end

  // stage 2: twiddle legs 1..3, lane 0 delayed alongside
  logic signed [DW-1:0] s2_re [NLANE];
  logic signed [DW-1:0] s2_im [NLANE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_re[0] <= '0;
      s2_im[0] <= '0;
    end else if (v_stage[S_CAP]) begin
      s2_re[0] <= s1_re[0];
      s2_im[0] <= s1_im[0];
    end
  end

  for (genvar g = 1; g < NLANE; g++) begin : g_leg
    r4bf_cmul #(.DW(DW), .TW(TW)) u_cmul (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (v_stage[S_CAP]),
      .x_re  (s1_re[g]),
      .x_im  (s1_im[g]),
      .w_re  (s1_wre[g-1]),
      .w_im  (s1_wim[g-1]),
      .p_re  (s2_re[g]),
      .p_im  (s2_im[g])
    );
  end

  // stage 3: first-level sums and differences
  logic signed [DW:0] sac_re, sac_im, dac_re, dac_im;
  logic signed [DW:0] sbd_re, sbd_im, dbd_re, dbd_im;

  r4bf_pair #(.W(DW)) u_pair (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (v_stage[S_MUL]),
    .a_re   (s2_re[0]), .a_im (s2_im[0]),
    .b_re   (s2_re[1]), .b_im (s2_im[1]),
    .c_re   (s2_re[2]), .c_im (s2_im[2]),
    .d_re   (s2_re[3]), .d_im (s2_im[3]),
    .sac_re (sac_re), .sac_im (sac_im),
    .dac_re (dac_re), .dac_im (dac_im),
    .sbd_re (sbd_re), .sbd_im (sbd_im),
    .dbd_re (dbd_re), .dbd_im (dbd_im)
  );

  // stage 4: output combination and divide by four
  r4bf_merge #(.W(DW)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (v_stage[S_PAIR]),
    .sac_re (sac_re), .sac_im (sac_im),
    .dac_re (dac_re), .dac_im (dac_im),
    .sbd_re (sbd_re), .sbd_im (sbd_im),
    .dbd_re (dbd_re), .dbd_im (dbd_im),
    .y_re   (out_re),
    .y_im   (out_im)
  );

  assign out_valid = v_stage[S_OUT];
endmodule

// File: rtl/r4bf_chk.sv
`timescale 1ns/1ps
module r4bf_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [3:0]    v_stage,
  input logic          out_valid,
  input logic [4*DW-1:0] out_re,
  input logic [4*DW-1:0] out_im
);
  // cycles since reset release, saturating, guards the latency look-back
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 3'd4)  since_rst <= since_rst + 3'd1;
  end

  // R1: reset clears the result side
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_re == '0 && out_im == '0));

  // R2: valid emerges exactly four edges after it entered
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R3: each stage hands its group on at the next edge, never stalls
  a_r3_cap_to_mul: assert property (@(posedge clk) disable iff (!rst_n)
    v_stage[1] == $past(v_stage[0]));
  a_r3_mul_to_pair: assert property (@(posedge clk) disable iff (!rst_n)
    v_stage[2] == $past(v_stage[1]));
  a_r3_pair_to_out: assert property (@(posedge clk) disable iff (!rst_n)
    v_stage[3] == $past(v_stage[2]));

  // R8: result held while no valid group is present
  a_r8_hold_re: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_re));
  a_r8_hold_im: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_im));
endmodule

bind r4bf_top r4bf_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .v_stage   (v_stage),
  .out_valid (out_valid),
  .out_re    (out_re),
  .out_im    (out_im)
);

// File: tb/r4bf_top_bench.sv
`timescale 1ns/1ps
module r4bf_top_bench;
  localparam int DW = 16;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b1;
  logic          in_valid = 1'b0;
  logic [63:0]   in_re = '0, in_im = '0;
  logic [47:0]   tw_re = '0, tw_im = '0;
  logic          out_valid;
  logic [63:0]   out_re, out_im;

  r4bf_top #(.DW(DW), .TW(TW)) u_r4bf_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_re(in_re), .in_im(in_im), .tw_re(tw_re), .tw_im(tw_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          q_v[$];
  logic [63:0] q_re[$];
  logic [63:0] q_im[$];
  string       q_tag[$];
  logic [63:0] hold_re = '0, hold_im = '0;

  // twiddled part: a*c (+/-) b*d, round half up at 2^-15, clamp to 16 bits
  function automatic int tw_part(int a, int b, int c, int d, bit minus);
    longint acc;
    acc = minus ? (longint'(a) * c - longint'(b) * d) : (longint'(a) * c + longint'(b) * d);
    acc = (acc + 64'sd16384) >>> 15;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return int'(acc);
  endfunction

  function automatic logic [63:0] pk4(int l0, int l1, int l2, int l3);
    return {16'(l3), 16'(l2), 16'(l1), 16'(l0)};
  endfunction

  function automatic logic [47:0] pk3(int l1, int l2, int l3);
    return {16'(l3), 16'(l2), 16'(l1)};
  endfunction

  task automatic model(input logic [63:0] xr, input logic [63:0] xi,
                       input logic [47:0] wr, input logic [47:0] wi,
                       output logic [63:0] yr, output logic [63:0] yi);
    int pr[4], pi[4], r[4], m[4];
    pr[0] = int'($signed(xr[15:0]));
    pi[0] = int'($signed(xi[15:0]));
    for (int k = 1; k < 4; k++) begin
      int a, b, c, d;
      a = int'($signed(xr[k*16 +: 16]));
      b = int'($signed(xi[k*16 +: 16]));
      c = int'($signed(wr[(k-1)*16 +: 16]));
      d = int'($signed(wi[(k-1)*16 +: 16]));
      pr[k] = tw_part(a, b, c, d, 1'b1);
      pi[k] = tw_part(a, b, d, c, 1'b0);
    end
    r[0] = pr[0] + pr[1] + pr[2] + pr[3];
    m[0] = pi[0] + pi[1] + pi[2] + pi[3];
    r[1] = pr[0] + pi[1] - pr[2] - pi[3];
    m[1] = pi[0] - pr[1] - pi[2] + pr[3];
    r[2] = pr[0] - pr[1] + pr[2] - pr[3];
    m[2] = pi[0] - pi[1] + pi[2] - pi[3];
    r[3] = pr[0] - pi[1] - pr[2] + pi[3];
    m[3] = pi[0] + pr[1] - pi[2] - pr[3];
    yr = pk4(r[0] >>> 2, r[1] >>> 2, r[2] >>> 2, r[3] >>> 2);
    yi = pk4(m[0] >>> 2, m[1] >>> 2, m[2] >>> 2, m[3] >>> 2);
  endtask

  task automatic compare_front();
    bit          ev;
    logic [63:0] er, ei;
    string       tg;
    if (q_v.size() < 4) return;
    ev = q_v.pop_front();
    er = q_re.pop_front();
    ei = q_im.pop_front();
    tg = q_tag.pop_front();
    if (ev) begin
      hold_re = er;
      hold_im = ei;
    end
    checks++;
    if (out_valid !== ev) begin
      errors++;
      $display("FAIL R2: out_valid=%0b expected %0b", out_valid, ev);
    end
    checks++;
    if (out_re !== hold_re || out_im !== hold_im) begin
      errors++;
      $display("FAIL %s: out_re=%h out_im=%h expected re=%h im=%h",
               ev ? tg : "R8", out_re, out_im, hold_re, hold_im);
    end
  endtask

  task automatic step(input bit v, input logic [63:0] xr, input logic [63:0] xi,
                      input logic [47:0] wr, input logic [47:0] wi, input string tg);
    logic [63:0] yr, yi;
    @(negedge clk);
    compare_front();
    in_valid = v;
    in_re = xr; in_im = xi; tw_re = wr; tw_im = wi;
    model(xr, xi, wr, wi, yr, yi);
    q_v.push_back(v);
    q_re.push_back(yr);
    q_im.push_back(yi);
    q_tag.push_back(tg);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [47:0] rnd48();
    return {16'($urandom()), $urandom()};
  endfunction

  initial begin
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || out_re !== '0 || out_im !== '0) begin
      errors++;
      $display("FAIL R1: out_valid=%0b out_re=%h out_im=%h expected 0 0 0",
               out_valid, out_re, out_im);
    end
    for (int i = 0; i < 4; i++) begin
      q_v.push_back(1'b0); q_re.push_back('0); q_im.push_back('0); q_tag.push_back("R1");
    end
    rst_n = 1'b1;

    // R7: zero twiddles, floor of x0/4 on every lane
    step(1, pk4(-1, 100, -200, 300), pk4(3, 7, 8, 9), '0, '0, "R7");
    step(1, pk4(4, 0, 0, 0), pk4(-5, 0, 0, 0), '0, '0, "R7");
    step(1, pk4(-4, 1, 1, 1), pk4(2, 1, 1, 1), '0, '0, "R7");

    // R4: near-unit and near-j twiddles, then lane order with mixed values
    step(1, pk4(400, 800, -1200, 1600), pk4(-40, 80, 120, -160),
         pk3(32767, 32767, 32767), '0, "R4");
    step(1, pk4(1000, 2000, 3000, 4000), pk4(0, 0, 0, 0),
         '0, pk3(32767, 32767, 32767), "R4");
    step(1, pk4(0, 8000, 0, 0), pk4(0, 0, 0, 0), pk3(32767, 0, 0), '0, "R4");
    step(1, pk4(0, 0, 0, 8000), pk4(0, 0, 0, 0), pk3(0, 0, 32767), '0, "R4");

    // R5: rounding ties with a one-half twiddle
    step(1, pk4(0, 1, -1, 3), pk4(0, 0, 0, 0), pk3(16384, 16384, 16384), '0, "R5");
    step(1, pk4(0, -3, 5, -5), pk4(0, 3, 0, 0), pk3(16384, 16384, 16384),
         pk3(16384, 0, 0), "R5");

    // R6: saturation of twiddled parts, both signs
    step(1, pk4(0, -32768, -32768, 32767), pk4(0, 0, -32768, 32767),
         pk3(-32768, -32768, 32767), pk3(0, 32767, -32768), "R6");
    step(1, pk4(0, 32767, -32768, -32768), pk4(0, 32767, 32767, -32768),
         pk3(-32768, 32767, -32768), pk3(-32768, -32768, -32768), "R6");

    // R8: idle cycles with changing inputs must not disturb the held result
    for (int i = 0; i < 6; i++) step(0, rnd64(), rnd64(), rnd48(), rnd48(), "R8");

    // R3: back-to-back full-range groups
    for (int i = 0; i < 40; i++) step(1, rnd64(), rnd64(), rnd48(), rnd48(), "R3");

    // R8 and R2: gapped traffic
    for (int i = 0; i < 60; i++)
      step(($urandom() % 3) != 0, rnd64(), rnd64(), rnd48(), rnd48(), "R4");

    for (int i = 0; i < 6; i++) step(0, '0, '0, '0, '0, "R8");
    @(negedge clk);
    compare_front();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule